// File: doc/BRIEF.md
# Banked Data Memory Address Mapper

This block turns the register operand of an 8-bit microcontroller instruction into a 9-bit physical data memory address. The data space is split into four banks of 128 bytes each. The low offsets of every bank hold special function registers, and general-purpose RAM sits above them. An operand of zero does not name a real register: it sends the access through an 8-bit pointer. The pointer is extended by a one-bit bank-pair select, so it can reach the whole 512-byte space without using the direct bank bits.

A small set of frequently used special registers is visible at the same offset in every bank. These are program counter low, status, pointer, program counter latch and interrupt control. The mapper folds them onto one canonical bank-0 address and flags them as shared. It also sorts each access into one of three classes: void, special register or general RAM. A void access is an indirect access whose pointer targets the indirection slot itself; it must read as zero and drop its write, so it cannot recurse. A separate path masks the 13-bit program counter so that the 4K-word program memory variant wraps into its first 4K words.

Top module: `bank_addr_map`

## Requirements
- R1: For a nonzero operand, the effective address is {bank_sel, op_addr}, with bank_sel in bits 8:7. phys_addr equals this address unless R4 applies. use_ptr is 0.
- R2: An operand of 00h sets use_ptr to 1 and forms the effective address as {ind_bank, ptr}, with ind_bank in bit 8. bank_sel has no effect on this address.
- R3: An indirect access whose effective offset (bits 6:0) is 00h sets void_access to 1. It drives phys_addr to 0 and clears is_sfr, is_gpr and is_common.
- R4: Effective offsets 02h, 03h, 04h, 0Ah and 0Bh in any bank set is_common and is_sfr. For these, phys_addr is the offset with bits 8:7 forced to 0.
- R5: Offsets 01h through 1Fh that are not void set is_sfr. Offsets 20h through 7Fh set is_gpr.
- R6: Exactly one of void_access, is_sfr and is_gpr is 1 for every input. is_common is set only together with is_sfr.
- R7: With SMALL_PROG=1 (the default), pc_out equals pc_in modulo 4096. With SMALL_PROG=0, pc_out equals pc_in.
- R8: For a nonzero operand, ind_bank and ptr have no effect on any data address output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_addr | input | 7 | Register operand taken from the instruction |
| bank_sel | input | 2 | Direct bank select |
| ind_bank | input | 1 | Bank-pair select for indirect access |
| ptr | input | 8 | Indirect pointer value |
| pc_in | input | 13 | Raw program counter |
| phys_addr | output | 9 | Physical data memory address |
| use_ptr | output | 1 | Access goes through the pointer |
| void_access | output | 1 | Access reads zero and discards its write |
| is_sfr | output | 1 | Target is a special register |
| is_gpr | output | 1 | Target is general-purpose RAM |
| is_common | output | 1 | Target is a register shared by all banks |
| pc_out | output | 13 | Program counter limited to the program space |

## Verification
Assertions inside the mapper check on every evaluation that the three access classes are mutually exclusive. They also check that a shared register always lands in bank 0, that a void access produces address zero, that a non-shared indirect access keeps the pointer bits, and that the program counter never exceeds the small space. Only the bench's sweeps can show the following: that each offset falls into the right class, that the exact set of shared offsets is correct, that the direct bank bits and the pointer are each ignored in the opposite mode, and that both program space variants give the right counter.

// File: rtl/bank_addr_map.sv
module bank_addr_map #(
  parameter int          OFS_W       = 7,
  parameter int          BANK_W      = 2,
  parameter int          SFR_TOP     = 32,
  parameter logic [31:0] COMMON_MASK = 32'h0000_0C1C,
  parameter int          PC_W        = 13,
  parameter bit          SMALL_PROG  = 1'b1
) (
  input  logic [OFS_W-1:0]        op_addr,
  input  logic [BANK_W-1:0]       bank_sel,
  input  logic [BANK_W-2:0]       ind_bank,
  input  logic [OFS_W:0]          ptr,
  input  logic [PC_W-1:0]         pc_in,
  output logic [BANK_W+OFS_W-1:0] phys_addr,
  output logic                    use_ptr,
  output logic                    void_access,
  output logic                    is_sfr,
  output logic                    is_gpr,
  output logic                    is_common,
  output logic [PC_W-1:0]         pc_out
);
  localparam int AW = BANK_W + OFS_W;
  localparam logic [PC_W-1:0] PC_MASK = {PC_W{1'b1}} >> (SMALL_PROG ? 1 : 0);

  logic [AW-1:0]    eff;
  logic [OFS_W-1:0] off;
  logic [31:0]      mask_sh;
  logic             low_zone;

  assign use_ptr     = (op_addr == '0);
  assign eff         = use_ptr ? {ind_bank, ptr} : {bank_sel, op_addr};
  assign off         = eff[OFS_W-1:0];
  assign low_zone    = 32'(off) < SFR_TOP;
  assign mask_sh     = COMMON_MASK >> off;
  assign void_access = (off == '0);
  assign is_sfr      = !void_access && low_zone;
  assign is_gpr      = !void_access && !low_zone;
  assign is_common   = is_sfr && mask_sh[0];
  assign phys_addr   = void_access ? '0 :
                       is_common   ? {{BANK_W{1'b0}}, off} : eff;
  assign pc_out      = pc_in & PC_MASK;

  always_comb begin
    // R6
    one_class_chk: assert ($onehot({void_access, is_sfr, is_gpr}));
    // R4
    common_bank0_chk: assert (!is_common || (is_sfr && phys_addr[AW-1:OFS_W] == '0));
    // R3
    void_zero_chk: assert (!void_access || (phys_addr == '0 && use_ptr));
    // R2
    ptr_keep_chk: assert (!(use_ptr && !void_access && !is_common) ||
                          phys_addr == {ind_bank, ptr});
    // R7
    pc_range_chk: assert (!SMALL_PROG || pc_out[PC_W-1] == 1'b0);
  end
endmodule

// File: tb/bank_addr_map_test.sv
module bank_addr_map_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [6:0]  op_addr;
  logic [1:0]  bank_sel;
  logic [0:0]  ind_bank;
  logic [7:0]  ptr;
  logic [12:0] pc_in;
  logic [8:0]  phys_addr;
  logic        use_ptr, void_access, is_sfr, is_gpr, is_common;
  logic [12:0] pc_out, pc_out_big;
  logic [8:0]  pa_big;
  logic        u_b, v_b, s_b, g_b, c_b;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  bank_addr_map uut (.op_addr, .bank_sel, .ind_bank, .ptr, .pc_in, .phys_addr,
    .use_ptr, .void_access, .is_sfr, .is_gpr, .is_common, .pc_out);

  bank_addr_map #(.SMALL_PROG(1'b0)) uut_big (.op_addr, .bank_sel, .ind_bank, .ptr,
    .pc_in, .phys_addr(pa_big), .use_ptr(u_b), .void_access(v_b), .is_sfr(s_b),
    .is_gpr(g_b), .is_common(c_b), .pc_out(pc_out_big));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h (op=%h bank=%h ib=%h ptr=%h pc=%h)",
               tag, act, exp, op_addr, bank_sel, ind_bank, ptr, pc_in);
    end
  endtask

  task automatic apply(int b, int op, int ib, int p, int pc);
    @(posedge clk);
    bank_sel = 2'(b); op_addr = 7'(op); ind_bank = 1'(ib); ptr = 8'(p); pc_in = 13'(pc);
    @(negedge clk);
  endtask

  task automatic check_map();
    int a, off;
    bit up, vd, sf, gp, cm;
    int ph;
    string tag;
    up  = (op_addr == 0);
    a   = up ? (int'(ind_bank) * 256 + int'(ptr)) : (int'(bank_sel) * 128 + int'(op_addr));
    off = a % 128;
    vd  = (off == 0);
    sf  = !vd && off < 32;
    gp  = !vd && off >= 32;
    cm  = !vd && (off == 2 || off == 3 || off == 4 || off == 10 || off == 11);
    ph  = vd ? 0 : (cm ? off : a);
    if (vd) tag = "R3";
    else if (cm) tag = "R4";
    else if (up) tag = "R2";
    else tag = "R1";
    chk(tag, {23'd0, phys_addr}, 32'(ph));
    chk("R5", {26'd0, use_ptr, void_access, is_sfr, is_gpr, is_common, 1'b0},
        {26'd0, up, vd, sf, gp, cm, 1'b0});
    // R6: exactly one class
    chk("R6", 32'($countones({void_access, is_sfr, is_gpr})), 32'd1);
  endtask

  initial begin
    apply(0, 0, 0, 0, 0);
    // initial state with all inputs zero: void indirect access (R3)
    chk("R3", {22'd0, void_access, phys_addr}, {22'd0, 1'b1, 9'd0});
    for (int b = 0; b < 4; b++)
      for (int op = 0; op < 128; op++) begin
        apply(b, op, (op ^ b) & 1, (b * 37 + op * 11) % 256, 0);
        check_map();
      end
    for (int ib = 0; ib < 2; ib++)
      for (int p = 0; p < 256; p++) begin
        apply(p % 4, 0, ib, p, 0);
        check_map();
      end
    // R8: pointer and bank pair do not move a direct access
    for (int op = 1; op < 128; op++) begin
      logic [8:0] first;
      apply(2, op, 0, 0, 0);
      first = phys_addr;
      apply(2, op, 1, 255, 0);
      chk("R8", {23'd0, phys_addr}, {23'd0, first});
      chk("R8", {31'd0, use_ptr}, 32'd0);
    end
    // R7: program counter wrap for both variants
    for (int pc = 0; pc < 8192; pc++) begin
      apply(1, 5, 0, 0, pc);
      chk("R7", {19'd0, pc_out}, 32'(pc % 4096));
      chk("R7", {19'd0, pc_out_big}, 32'(pc));
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule